// File: doc/BRIEF.md
# Real-Time Clock with Wake-Up Compare

This block keeps a 48-bit time-of-day count that advances by one on every pulse of a 32.768 kHz tick enable, itself running on a faster system clock. Software never touches the count directly. It exchanges values with a 48-bit holding buffer: a read command snapshots the live count into the buffer, and a write command arms a load that copies the buffer into the count on the next tick. Time values arriving in broadcast packets are first corrected by a receive-delay offset. In automatic mode the corrected value goes straight into the count. In manual mode it is parked in the buffer, where software can commit it later with a write command. The value offered for transmission is the live count plus a transmit-delay offset.

A 24-bit wake-up time is assembled one byte at a time. One strobe bit per byte selects which byte takes the write. When wake-up is enabled and this time equals count bits 31:8, the block emits a single-cycle wake pulse. It also divides the tick by eight to produce a 4.096 kHz power-management tick.

The load sequencer has two states. SEQ_IDLE moves to SEQ_LOAD_WAIT on a write command (transition ARM). SEQ_LOAD_WAIT returns to SEQ_IDLE on the next tick, which loads the count from the buffer (transition COMMIT). It also returns to SEQ_IDLE when an automatic packet load arrives, which drops the armed load (transition CANCEL).

Top module: `rtc_wake_timer`

## Requirements
- R1: After reset the count, the buffer, the wake-up time, `wake_pulse_o` and `pm_tick_o` are all zero.
- R2: The count rises by one, modulo 2^48, on each cycle with `tick_i` high, and holds on cycles without a tick.
- R3: A cycle with `rd_cmd_i` high copies the count into the buffer. The copy is visible on `buf_rdata_o` one cycle later.
- R4: A `wr_cmd_i` pulse leaves the count unchanged until the next tick. On that tick the count takes the buffer value. Counting then continues from the loaded value.
- R5: In automatic mode (`pkt_auto_i`=1), a cycle with `pkt_rx_valid_i` loads the count with `pkt_rx_time_i + rx_adj_i` in the next cycle. The buffer is left unchanged, and any armed write is cancelled.
- R6: In manual mode (`pkt_auto_i`=0), a received packet puts `pkt_rx_time_i + rx_adj_i` into the buffer and leaves counting unaffected.
- R7: `tx_time_o` always equals the count plus the zero-extended `tx_adj_i`, modulo 2^48.
- R8: Bit k of `wake_sel_i` loads `wake_byte_i` into bits 8k+7:8k of the wake-up time. Bytes whose strobe is low keep their value.
- R9: With `wake_en_i` high, `wake_pulse_o` is high for exactly one cycle, one cycle after count bits 31:8 first equal the wake-up time. It stays low while the equality persists. Count bits 47:32 and 7:0 are ignored.
- R10: With `wake_en_i` low no wake pulse is produced. Raising the enable while the equality holds produces a pulse in the next cycle.
- R11: `pm_tick_o` is high for one cycle on every eighth tick since reset, in the same cycle the count advances for that tick.
- R12: Buffer update priority is: read command first, then manual packet, then software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 32.768 kHz tick enable |
| rd_cmd_i | input | 1 | Copy count into buffer |
| wr_cmd_i | input | 1 | Arm load of buffer into count at next tick |
| buf_we_i | input | 1 | Software write of the buffer |
| buf_wdata_i | input | 48 | Software buffer write data |
| buf_rdata_o | output | 48 | Buffer contents |
| pkt_rx_valid_i | input | 1 | Received time packet value valid |
| pkt_rx_time_i | input | 48 | Time value carried by the received packet |
| pkt_auto_i | input | 1 | 1: packet loads count, 0: packet loads buffer |
| rx_adj_i | input | 8 | Receive-delay correction added to packet values |
| tx_adj_i | input | 8 | Transmit-delay correction added to the sent time |
| tx_time_o | output | 48 | Time value to transmit (count + tx_adj_i) |
| wake_byte_i | input | 8 | Wake-up time byte data |
| wake_sel_i | input | 3 | Per-byte write strobes for the wake-up time |
| wake_en_i | input | 1 | Wake-up compare enable |
| wake_pulse_o | output | 1 | Single-cycle wake event |
| pm_tick_o | output | 1 | Power-management tick (tick / 8) |

## Verification
The bench sweeps all 256 transmit offsets and checks the power-management divider on every tick. It drives the count across its 48-bit wrap, which a design with a narrow adder or an off-by-one load would corrupt. It cancels an armed write with an automatic packet and checks the count afterwards: a sequencer that keeps the load armed would overwrite the packet time on the next tick. It also drives simultaneous buffer updates, where a wrong priority leaves the wrong value in the buffer.

For the wake compare, the bench approaches the match from below and holds it for several ticks, so a level output or a late pulse is caught. It rewrites a single byte, so a strobe that touches the wrong lane is caught. It loads counts that differ only in the upper 16 bits, and it raises the enable while the match already holds, which exposes a compare on the wrong slice and an edge detector that ignores the enable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE      = 1'b0,
        SEQ_LOAD_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/rtc_seq.sv
module rtc_seq
    import rtc_pkg::*;
#(
    parameter int unsigned CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_cmd_i,
    input  logic             auto_ld_i,
    input  logic [CNT_W-1:0] auto_val_i,
    input  logic [CNT_W-1:0] buf_i,
    output logic [CNT_W-1:0] count_o
);
    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] count_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // transitions ARM, COMMIT, CANCEL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (!auto_ld_i && wr_cmd_i) state_d = SEQ_LOAD_WAIT;
            end
            SEQ_LOAD_WAIT: begin
                if (auto_ld_i || tick_i) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // output process: the count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (auto_ld_i) begin
            count_q <= auto_val_i;
        end else if (tick_i) begin
            if (state_q == SEQ_LOAD_WAIT) count_q <= buf_i;
            else                          count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;

    // R2: one step per tick when nothing loads
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !auto_ld_i && state_q == SEQ_IDLE) |=> (count_o == $past(count_o) + CNT_W'(1)));
    // R2: hold without tick or load
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !auto_ld_i) |=> $stable(count_o));
    // R4: armed load commits on the tick
    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LOAD_WAIT && tick_i && !auto_ld_i) |=> (count_o == $past(buf_i)));
    // R5: automatic packet load wins and disarms
    p_auto_r5: assert property (@(posedge clk) disable iff (!rst_n)
        auto_ld_i |=> (count_o == $past(auto_val_i) && state_q == SEQ_IDLE));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
    parameter int unsigned CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             man_ld_i,
    input  logic [CNT_W-1:0] man_val_i,
    input  logic             sw_we_i,
    input  logic [CNT_W-1:0] sw_val_i,
    output logic [CNT_W-1:0] buf_o
);
    logic [CNT_W-1:0] buf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        buf_q <= '0;
        else if (rd_cmd_i) buf_q <= count_i;
        else if (man_ld_i) buf_q <= man_val_i;
        else if (sw_we_i)  buf_q <= sw_val_i;
    end

    assign buf_o = buf_q;

    // R3: read snapshot
    p_rd_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_i |=> (buf_o == $past(count_i)));
    // R6 / R12: manual packet beats software write
    p_man_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (man_ld_i && !rd_cmd_i) |=> (buf_o == $past(man_val_i)));
    // R12: no source, no change
    p_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd_i && !man_ld_i && !sw_we_i) |=> $stable(buf_o));
endmodule

// File: rtl/rtc_wake_cmp.sv
module rtc_wake_cmp #(
    parameter int unsigned CNT_W      = 48,
    parameter int unsigned WAKE_LSB   = 8,
    parameter int unsigned WAKE_BYTES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            byte_i,
    input  logic [WAKE_BYTES-1:0] sel_i,
    input  logic                  en_i,
    input  logic [CNT_W-1:0]      count_i,
    output logic                  wake_o
);
    localparam int unsigned WAKE_W = 8 * WAKE_BYTES;

    logic [WAKE_W-1:0] wake_q;
    logic              hit, hit_q, wake_q_o;

    for (genvar b = 0; b < WAKE_BYTES; b++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        wake_q[b*8 +: 8] <= 8'h00;
            else if (sel_i[b]) wake_q[b*8 +: 8] <= byte_i;
        end
        // R8: unselected lane holds
        p_lane_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_i[b] |=> $stable(wake_q[b*8 +: 8]));
    end

    assign hit = en_i && (count_i[WAKE_LSB +: WAKE_W] == wake_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q    <= 1'b0;
            wake_q_o <= 1'b0;
        end else begin
            hit_q    <= hit;
            wake_q_o <= hit && !hit_q;
        end
    end

    assign wake_o = wake_q_o;

    // R9: pulse lasts one cycle
    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R10: disabled compare stays silent
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !wake_o);
endmodule

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int unsigned DIV_LOG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic pm_o
);
    logic [DIV_LOG-1:0] div_q;
    logic               pm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            pm_q  <= 1'b0;
        end else begin
            pm_q <= tick_i && (div_q == {DIV_LOG{1'b1}});
            if (tick_i) div_q <= div_q + DIV_LOG'(1);
        end
    end

    assign pm_o = pm_q;

    // R11: a power-management tick only follows a real tick
    p_pm_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pm_o |-> $past(tick_i));
endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer #(
    parameter int unsigned CNT_W      = 48,
    parameter int unsigned ADJ_W      = 8,
    parameter int unsigned WAKE_LSB   = 8,
    parameter int unsigned WAKE_BYTES = 3,
    parameter int unsigned PM_LOG     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  rd_cmd_i,
    input  logic                  wr_cmd_i,
    input  logic                  buf_we_i,
    input  logic [CNT_W-1:0]      buf_wdata_i,
    output logic [CNT_W-1:0]      buf_rdata_o,
    input  logic                  pkt_rx_valid_i,
    input  logic [CNT_W-1:0]      pkt_rx_time_i,
    input  logic                  pkt_auto_i,
    input  logic [ADJ_W-1:0]      rx_adj_i,
    input  logic [ADJ_W-1:0]      tx_adj_i,
    output logic [CNT_W-1:0]      tx_time_o,
    input  logic [7:0]            wake_byte_i,
    input  logic [WAKE_BYTES-1:0] wake_sel_i,
    input  logic                  wake_en_i,
    output logic                  wake_pulse_o,
    output logic                  pm_tick_o
);
    logic [CNT_W-1:0] count, buf_val, rx_corr;
    logic             auto_ld, man_ld;

    assign rx_corr   = pkt_rx_time_i + {{(CNT_W-ADJ_W){1'b0}}, rx_adj_i};
    assign auto_ld   = pkt_rx_valid_i && pkt_auto_i;
    assign man_ld    = pkt_rx_valid_i && !pkt_auto_i;
    assign tx_time_o = count + {{(CNT_W-ADJ_W){1'b0}}, tx_adj_i};
    assign buf_rdata_o = buf_val;

    rtc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_cmd_i(wr_cmd_i),
        .auto_ld_i(auto_ld), .auto_val_i(rx_corr), .buf_i(buf_val),
        .count_o(count)
    );

    rtc_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .rd_cmd_i(rd_cmd_i), .count_i(count),
        .man_ld_i(man_ld), .man_val_i(rx_corr),
        .sw_we_i(buf_we_i), .sw_val_i(buf_wdata_i), .buf_o(buf_val)
    );

    rtc_wake_cmp #(.CNT_W(CNT_W), .WAKE_LSB(WAKE_LSB), .WAKE_BYTES(WAKE_BYTES)) u_wake (
        .clk(clk), .rst_n(rst_n), .byte_i(wake_byte_i), .sel_i(wake_sel_i),
        .en_i(wake_en_i), .count_i(count), .wake_o(wake_pulse_o)
    );

    rtc_prescale #(.DIV_LOG(PM_LOG)) u_pm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pm_o(pm_tick_o)
    );
endmodule

// File: tb/sim_rtc_wake_timer.sv
module sim_rtc_wake_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 0, rd_cmd = 0, wr_cmd = 0, buf_we = 0;
    logic [47:0] buf_wdata = '0, buf_rdata, pkt_time = '0, tx_time;
    logic        pkt_valid = 0, pkt_auto = 0;
    logic [7:0]  rx_adj = '0, tx_adj = '0, wake_byte = '0;
    logic [2:0]  wake_sel = '0;
    logic        wake_en = 0, wake_pulse, pm_tick;

    int checks = 0, errors = 0, tick_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_wake_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rd_cmd_i(rd_cmd), .wr_cmd_i(wr_cmd),
        .buf_we_i(buf_we), .buf_wdata_i(buf_wdata), .buf_rdata_o(buf_rdata),
        .pkt_rx_valid_i(pkt_valid), .pkt_rx_time_i(pkt_time), .pkt_auto_i(pkt_auto),
        .rx_adj_i(rx_adj), .tx_adj_i(tx_adj), .tx_time_o(tx_time),
        .wake_byte_i(wake_byte), .wake_sel_i(wake_sel), .wake_en_i(wake_en),
        .wake_pulse_o(wake_pulse), .pm_tick_o(pm_tick)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick1();
        @(negedge clk) tick = 1;
        @(negedge clk) tick = 0;
        tick_cnt++;
        chk("R11 pm tick", 48'(pm_tick), 48'((tick_cnt % 8) == 0));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_rd();
        @(negedge clk) rd_cmd = 1;
        @(negedge clk) rd_cmd = 0;
    endtask

    task automatic wr_buf(input logic [47:0] v);
        @(negedge clk) begin buf_we = 1; buf_wdata = v; end
        @(negedge clk) buf_we = 0;
    endtask

    task automatic do_wr();
        @(negedge clk) wr_cmd = 1;
        @(negedge clk) wr_cmd = 0;
    endtask

    task automatic pkt(input logic [47:0] v, input logic auto_m);
        @(negedge clk) begin pkt_valid = 1; pkt_time = v; pkt_auto = auto_m; end
        @(negedge clk) pkt_valid = 0;
    endtask

    task automatic wbyte(input logic [2:0] sel, input logic [7:0] b);
        @(negedge clk) begin wake_sel = sel; wake_byte = b; end
        @(negedge clk) wake_sel = '0;
    endtask

    task automatic load_count(input logic [47:0] v);
        wr_buf(v);
        do_wr();
        tick1();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        chk("R1 buffer", buf_rdata, '0);
        chk("R1 count", tx_time, '0);
        chk("R1 wake", 48'(wake_pulse), '0);
        chk("R1 pm", 48'(pm_tick), '0);

        // R2 / R11 counting sweep
        for (int i = 1; i <= 20; i++) begin
            tick1();
            chk("R2 count step", tx_time, 48'(i));
        end
        idle(3);
        chk("R2 hold", tx_time, 48'd20);
        do_rd();
        chk("R3 read snapshot", buf_rdata, 48'd20);

        // R7 full offset sweep
        for (int a = 0; a < 256; a++) begin
            @(negedge clk) tx_adj = 8'(a);
            #1 chk("R7 tx offset", tx_time, 48'd20 + 48'(a));
        end
        @(negedge clk) tx_adj = '0;

        // R4 armed write, wrap across 2^48
        wr_buf(48'hFFFF_FFFF_FFFD);
        do_wr();
        idle(4);
        chk("R4 no load before tick", tx_time, 48'd20);
        tick1();
        chk("R4 load on tick", tx_time, 48'hFFFF_FFFF_FFFD);
        tick1(); tick1(); tick1();
        chk("R4 R2 wrap", tx_time, 48'h0);

        // R5 automatic packet
        @(negedge clk) rx_adj = 8'h21;
        pkt(48'h0000_1234_5678, 1'b1);
        chk("R5 auto load", tx_time, 48'h0000_1234_5699);
        chk("R5 buffer kept", buf_rdata, 48'hFFFF_FFFF_FFFD);
        do_wr();
        pkt(48'h0000_0000_1000, 1'b1);
        chk("R5 auto during armed", tx_time, 48'h1021);
        tick1();
        chk("R5 armed write cancelled", tx_time, 48'h1022);

        // R6 manual packet
        pkt(48'h0A0B_0C0D_0E00, 1'b0);
        chk("R6 manual to buffer", buf_rdata, 48'h0A0B_0C0D_0E21);
        chk("R6 count untouched", tx_time, 48'h1022);
        tick1();
        chk("R6 count keeps ticking", tx_time, 48'h1023);
        do_wr();
        tick1();
        chk("R6 commit parked value", tx_time, 48'h0A0B_0C0D_0E21);

        // R12 priority
        @(negedge clk) begin
            rd_cmd = 1; pkt_valid = 1; pkt_auto = 0; pkt_time = 48'h100;
            buf_we = 1; buf_wdata = 48'h5555;
        end
        @(negedge clk) rd_cmd = 0;
        chk("R12 read wins", buf_rdata, 48'h0A0B_0C0D_0E21);
        @(negedge clk) begin pkt_valid = 0; buf_we = 0; end
        chk("R12 packet over sw write", buf_rdata, 48'h121);
        wr_buf(48'h5555);
        chk("R12 sw write alone", buf_rdata, 48'h5555);

        // R8 / R9 wake compare
        wbyte(3'b100, 8'h12);
        wbyte(3'b001, 8'h56);
        wbyte(3'b010, 8'h34);
        @(negedge clk) wake_en = 1;
        load_count(48'h0000_1234_55FE);
        idle(2);
        chk("R9 no early pulse", 48'(wake_pulse), '0);
        tick1();
        @(negedge clk);
        chk("R9 no pulse below", 48'(wake_pulse), '0);
        tick1();
        chk("R9 not before latency", 48'(wake_pulse), '0);
        @(negedge clk);
        chk("R9 pulse", 48'(wake_pulse), 48'd1);
        @(negedge clk);
        chk("R9 single cycle", 48'(wake_pulse), '0);
        for (int i = 0; i < 5; i++) begin
            tick1();
            @(negedge clk);
            chk("R9 no repeat while equal", 48'(wake_pulse), '0);
        end
        load_count(48'h0000_0000_0000);
        load_count(48'hBEEF_1234_5600);
        @(negedge clk);
        chk("R9 upper bits ignored", 48'(wake_pulse), 48'd1);

        // R8 single lane rewrite
        wbyte(3'b010, 8'hAB);
        load_count(48'h0000_1234_5600);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 old byte replaced", 48'(wake_pulse), '0);
        end
        load_count(48'h0000_12AB_5600);
        @(negedge clk);
        chk("R8 new byte matches", 48'(wake_pulse), 48'd1);

        // R10 enable gating
        @(negedge clk) wake_en = 0;
        load_count(48'h0);
        load_count(48'h0000_12AB_5600);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 disabled silent", 48'(wake_pulse), '0);
        end
        @(negedge clk) wake_en = 1;
        @(negedge clk);
        chk("R10 enable while equal", 48'(wake_pulse), 48'd1);
        @(negedge clk);
        chk("R10 then low", 48'(wake_pulse), '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule